// File: doc/BRIEF.md
# Tuning Word History Averager

This block sits next to the loop filter of a digital PLL and watches the 48-bit frequency tuning word that the loop produces, one valid-qualified sample at a time. It sums the samples over a programmable interval, counted in accepted samples. At the end of each interval it divides the sum by the sample count and writes the quotient into a holdover history register. If the loop later has to run open-loop, it can use that register as a frequency estimate. Each interval's result uses only that interval's samples. Nothing is carried over from earlier intervals, so the block does not compute a sliding mean.

A long interval means a long wait before any history exists. To shorten that wait, a 3-bit count K asks for extra early averages inside the first interval after a clear. They fall at the sample counts floor(T/2^K), floor(T/2^(K-1)), up to floor(T/2). Each one covers every sample taken since the clear. The history is cleared by reset, by a software clear, by a hardware clear, or by a reference switch unless the persistent-history enable is set. The divider is sequential, so a new result appears some cycles after the sample that completes it. Each result is announced by a one-cycle strobe in the same cycle that the register takes the new value.

Top module: `ftw_hist_avg`

## Requirements
- R1: After reset, `hist_word` is 0, `hist_valid` is 0 and `hist_strobe` is 0.
- R2: With `early_cnt` = 0, the register receives floor(S/T) once T samples have been accepted since the last full interval or clear, where S is the sum of those T samples. The sum and count then restart from zero, so the next result depends only on the next T samples.
- R3: `hist_strobe` is high for exactly one cycle per stored result. `hist_word` changes only in a strobe cycle or in the cycle after a clear.
- R4: With `early_cnt` = 0, no result is stored and `hist_valid` stays 0 until the first full interval after a clear completes.
- R5: In the first interval after a clear, for each j from 1 to `early_cnt`, an extra result floor(S/n) is stored when the sample count n reaches floor(T/2^j), provided that value is nonzero. S is the sum of all samples since the clear. No early results occur in later intervals.
- R6: A one-cycle pulse on `sw_clear` or `hw_clear` sets `hist_word` and `hist_valid` to 0 on the next cycle. It empties the sum and the count, restarts the first-interval schedule, and drops any result still being divided.
- R7: A `ref_switch` pulse acts as a clear (R6) when `keep_hist` is 0. When `keep_hist` is 1 it has no effect: the stored value, the valid flag and the running sum are all kept.
- R8: While `interval_len` is 0, samples are ignored and no results or strobes are produced.
- R9: `hist_valid` rises in the cycle of the first strobe after a clear, whether that result is early or full, and is high whenever the strobe is high.
- R10: A clear in the same cycle as a valid sample wins: that sample is dropped from the new accumulation.
- R11: Results are exact (the quotient is truncated) for words up to 2^48-1 summed over the maximum interval, provided results are spaced at least `ACC_W`+4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ftw_in | input | WORD_W | Tuning word sample |
| ftw_vld | input | 1 | Sample qualifier |
| interval_len | input | CNT_W | Interval length T in samples; 0 disables |
| early_cnt | input | K_W | Number of early averages K in the first interval |
| keep_hist | input | 1 | Keep history across a reference switch |
| sw_clear | input | 1 | Software history clear pulse |
| hw_clear | input | 1 | Hardware history clear pulse |
| ref_switch | input | 1 | Reference switchover pulse |
| hist_word | output | WORD_W | Stored average tuning word |
| hist_valid | output | 1 | A stored average exists |
| hist_strobe | output | 1 | One-cycle pulse when hist_word is written |

## Verification
The hardest case to reach from the ports is a clear that arrives while a quotient is still inside the sequential divider. If the block wrongly lets that stale result through, the output can look plausible. To reach it, the stimulus ends a milestone with a sample, waits a few cycles with no idle gap, and then pulses the clear. It then watches that no strobe follows and that the next interval's result is built only from post-clear samples. A second hard case is a clear in the same cycle as a valid sample. It is reached by driving both on one edge with an extreme word value, so that the dropped sample would visibly distort the next average if it leaked in.

// File: rtl/ftw_hist_pkg.sv
package ftw_hist_pkg;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    function automatic logic hist_clear_req(input logic sw_clr,
                                            input logic hw_clr,
                                            input logic ref_sw,
                                            input logic keep);
        return sw_clr | hw_clr | (ref_sw & ~keep);
    endfunction

endpackage

// File: rtl/ftw_hist_sched.sv
module ftw_hist_sched #(
    parameter int CNT_W = 16,
    parameter int K_W   = 3
) (
    input  logic [CNT_W-1:0] cnt_new,
    input  logic [CNT_W-1:0] len,
    input  logic [K_W-1:0]   k_sel,
    input  logic             first_iv,
    output logic             full_hit,
    output logic             early_hit
);
    localparam int NSTEP = (1 << K_W) - 1;

    logic [NSTEP:1] step_hit;

    // One comparator per possible early point T/2^j
    generate
        for (genvar j = 1; j <= NSTEP; j++) begin : g_step
            assign step_hit[j] = (k_sel >= K_W'(j))
                               && (cnt_new == (len >> j))
                               && (cnt_new != '0);
        end
    endgenerate

    always_comb begin
        full_hit  = (len != '0) && (cnt_new >= len);
        early_hit = first_iv && !full_hit && (|step_hit);
    end
endmodule

// File: rtl/ftw_hist_acc.sv
module ftw_hist_acc #(
    parameter int WORD_W = 48,
    parameter int CNT_W  = 16,
    parameter int K_W    = 3,
    localparam int ACC_W = WORD_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    input  logic [CNT_W-1:0]  len,
    input  logic [K_W-1:0]    k_sel,
    output logic              req_vld,
    output logic [ACC_W-1:0]  req_sum,
    output logic [CNT_W-1:0]  req_cnt
);
    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             first;
        logic             rv;
        logic [ACC_W-1:0] rsum;
        logic [CNT_W-1:0] rcnt;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [ACC_W-1:0] sum_new;
    logic [CNT_W-1:0] cnt_new;
    logic             full_hit;
    logic             early_hit;

    assign sum_new = acc_q.sum + ACC_W'(word_in);
    assign cnt_new = acc_q.cnt + CNT_W'(1);

    ftw_hist_sched #(.CNT_W(CNT_W), .K_W(K_W)) i_sched (
        .cnt_new  (cnt_new),
        .len      (len),
        .k_sel    (k_sel),
        .first_iv (acc_q.first),
        .full_hit (full_hit),
        .early_hit(early_hit)
    );

    always_comb begin
        acc_d    = acc_q;
        acc_d.rv = 1'b0;
        if (clr) begin
            acc_d.sum   = '0;
            acc_d.cnt   = '0;
            acc_d.first = 1'b1;
        end else if (word_vld && (len != '0)) begin
            if (full_hit || early_hit) begin
                acc_d.rv   = 1'b1;
                acc_d.rsum = sum_new;
                acc_d.rcnt = cnt_new;
            end
            if (full_hit) begin
                acc_d.sum   = '0;
                acc_d.cnt   = '0;
                acc_d.first = 1'b0;
            end else begin
                acc_d.sum = sum_new;
                acc_d.cnt = cnt_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q       <= '0;
            acc_q.first <= 1'b1;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign req_vld = acc_q.rv;
    assign req_sum = acc_q.rsum;
    assign req_cnt = acc_q.rcnt;
endmodule

// File: rtl/ftw_hist_div.sv
module ftw_hist_div
    import ftw_hist_pkg::*;
#(
    parameter int NUM_W  = 64,
    parameter int DEN_W  = 16,
    localparam int STEP_W = $clog2(NUM_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             req_vld,
    input  logic [NUM_W-1:0] req_num,
    input  logic [DEN_W-1:0] req_den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    typedef struct packed {
        div_state_e        st;
        logic [DEN_W:0]    rem;
        logic [NUM_W-1:0]  quo;
        logic [DEN_W-1:0]  den;
        logic [STEP_W-1:0] step;
        logic              pend_vld;
        logic [NUM_W-1:0]  pend_num;
        logic [DEN_W-1:0]  pend_den;
        logic              done;
        logic [NUM_W-1:0]  result;
    } div_t;

    div_t div_d, div_q;

    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   rem_sub;
    logic             fits;
    logic [NUM_W-1:0] quo_sh;

    // One restoring step: bring down the next dividend bit, subtract if it fits
    assign rem_sh  = {div_q.rem[DEN_W-1:0], div_q.quo[NUM_W-1]};
    assign rem_sub = rem_sh - {1'b0, div_q.den};
    assign fits    = rem_sh >= {1'b0, div_q.den};
    assign quo_sh  = {div_q.quo[NUM_W-2:0], fits};

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        if (abort) begin
            div_d.st       = DIV_IDLE;
            div_d.pend_vld = 1'b0;
        end else begin
            unique case (div_q.st)
                DIV_IDLE: begin
                    if (div_q.pend_vld) begin
                        div_d.st       = DIV_RUN;
                        div_d.rem      = '0;
                        div_d.quo      = div_q.pend_num;
                        div_d.den      = div_q.pend_den;
                        div_d.step     = '0;
                        div_d.pend_vld = 1'b0;
                    end
                end
                DIV_RUN: begin
                    div_d.rem  = fits ? rem_sub : rem_sh;
                    div_d.quo  = quo_sh;
                    div_d.step = div_q.step + STEP_W'(1);
                    if (div_q.step == STEP_W'(NUM_W - 1)) begin
                        div_d.st     = DIV_IDLE;
                        div_d.done   = 1'b1;
                        div_d.result = quo_sh;
                    end
                end
                default: div_d.st = DIV_IDLE;
            endcase
            // A newer request replaces one still waiting
            if (req_vld) begin
                div_d.pend_vld = 1'b1;
                div_d.pend_num = req_num;
                div_d.pend_den = req_den;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            div_q.st <= DIV_IDLE;
        end else begin
            div_q <= div_d;
        end
    end

    assign done = div_q.done;
    assign quot = div_q.result;
endmodule

// File: rtl/ftw_hist_avg.sv
module ftw_hist_avg
    import ftw_hist_pkg::*;
#(
    parameter int WORD_W = 48,
    parameter int CNT_W  = 16,
    parameter int K_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ftw_in,
    input  logic              ftw_vld,
    input  logic [CNT_W-1:0]  interval_len,
    input  logic [K_W-1:0]    early_cnt,
    input  logic              keep_hist,
    input  logic              sw_clear,
    input  logic              hw_clear,
    input  logic              ref_switch,
    output logic [WORD_W-1:0] hist_word,
    output logic              hist_valid,
    output logic              hist_strobe
);
    localparam int ACC_W = WORD_W + CNT_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              strobe;
    } hist_t;

    hist_t hist_d, hist_q;

    logic             clr;
    logic             req_vld;
    logic [ACC_W-1:0] req_sum;
    logic [CNT_W-1:0] req_cnt;
    logic             div_done;
    logic [ACC_W-1:0] div_quot;

    assign clr = hist_clear_req(sw_clear, hw_clear, ref_switch, keep_hist);

    ftw_hist_acc #(.WORD_W(WORD_W), .CNT_W(CNT_W), .K_W(K_W)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .word_in (ftw_in),
        .word_vld(ftw_vld),
        .len     (interval_len),
        .k_sel   (early_cnt),
        .req_vld (req_vld),
        .req_sum (req_sum),
        .req_cnt (req_cnt)
    );

    ftw_hist_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (clr),
        .req_vld(req_vld),
        .req_num(req_sum),
        .req_den(req_cnt),
        .done   (div_done),
        .quot   (div_quot)
    );

    always_comb begin
        hist_d        = hist_q;
        hist_d.strobe = 1'b0;
        if (clr) begin
            hist_d.word  = '0;
            hist_d.valid = 1'b0;
        end else if (div_done) begin
            hist_d.word   = div_quot[WORD_W-1:0];
            hist_d.valid  = 1'b1;
            hist_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_word   = hist_q.word;
    assign hist_valid  = hist_q.valid;
    assign hist_strobe = hist_q.strobe;
endmodule

// File: rtl/ftw_hist_avg_chk.sv
module ftw_hist_avg_chk #(
    parameter int WORD_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_clear,
    input logic              hw_clear,
    input logic              ref_switch,
    input logic              keep_hist,
    input logic [WORD_W-1:0] hist_word,
    input logic              hist_valid,
    input logic              hist_strobe
);
    logic clr_now;
    logic armed_q;
    logic clr_prev_q;

    assign clr_now = sw_clear | hw_clear | (ref_switch & ~keep_hist);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            clr_prev_q <= 1'b0;
        end else begin
            armed_q    <= 1'b1;
            clr_prev_q <= clr_now;
        end
    end

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (!hist_valid && (hist_word == '0) && !hist_strobe));

    assert_strobe_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hist_strobe |=> !hist_strobe);

    assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !hist_strobe && !clr_prev_q) |-> $stable(hist_word));

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hist_valid) |-> hist_strobe);

    assert_strobe_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hist_strobe |-> hist_valid);
endmodule

bind ftw_hist_avg ftw_hist_avg_chk #(.WORD_W(WORD_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_clear   (sw_clear),
    .hw_clear   (hw_clear),
    .ref_switch (ref_switch),
    .keep_hist  (keep_hist),
    .hist_word  (hist_word),
    .hist_valid (hist_valid),
    .hist_strobe(hist_strobe)
);

// File: tb/test_ftw_hist_avg.sv
module test_ftw_hist_avg;
    localparam int WORD_W = 48;
    localparam int CNT_W  = 16;
    localparam int K_W    = 3;
    localparam int GAP    = 80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] ftw_in = '0;
    logic              ftw_vld = 1'b0;
    logic [CNT_W-1:0]  interval_len = '0;
    logic [K_W-1:0]    early_cnt = '0;
    logic              keep_hist = 1'b0;
    logic              sw_clear = 1'b0;
    logic              hw_clear = 1'b0;
    logic              ref_switch = 1'b0;
    logic [WORD_W-1:0] hist_word;
    logic              hist_valid;
    logic              hist_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    int n_strobe = 0;
    logic strobe_prev = 1'b0;

    logic [WORD_W-1:0] exp_q[$];
    logic [63:0]       m_sum = '0;
    int                m_cnt = 0;
    bit                m_first = 1'b1;

    always #10 clk = ~clk;

    ftw_hist_avg #(.WORD_W(WORD_W), .CNT_W(CNT_W), .K_W(K_W)) i_ftw_hist_avg (
        .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .ftw_vld(ftw_vld),
        .interval_len(interval_len), .early_cnt(early_cnt), .keep_hist(keep_hist),
        .sw_clear(sw_clear), .hw_clear(hw_clear), .ref_switch(ref_switch),
        .hist_word(hist_word), .hist_valid(hist_valid), .hist_strobe(hist_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop an expected average for every strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (hist_strobe) begin
                n_strobe++;
                check(!strobe_prev, "R3 strobe width", 64'(strobe_prev), 64'd0);
                check(hist_valid, "R9 valid with strobe", 64'(hist_valid), 64'd1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", 64'(hist_word), 64'd0);
                end else begin
                    logic [WORD_W-1:0] e;
                    e = exp_q.pop_front();
                    check(hist_word == e, "R2/R5 average", 64'(hist_word), 64'(e));
                end
            end
            strobe_prev = hist_strobe;
        end
    end

    // Driver: applies a sample and predicts the result it completes, if any
    task automatic send(input logic [WORD_W-1:0] w, input int gap);
        @(negedge clk);
        ftw_in  = w;
        ftw_vld = 1'b1;
        @(negedge clk);
        ftw_vld = 1'b0;
        if (interval_len != 0) begin
            bit early;
            m_sum = m_sum + 64'(w);
            m_cnt++;
            early = 1'b0;
            for (int j = 1; j <= int'(early_cnt); j++)
                if (m_cnt == int'(interval_len >> j) && m_cnt != 0) early = 1'b1;
            if (m_cnt >= int'(interval_len)) begin
                exp_q.push_back(WORD_W'(m_sum / 64'(m_cnt)));
                m_sum = '0;
                m_cnt = 0;
                m_first = 1'b0;
            end else if (m_first && early) begin
                exp_q.push_back(WORD_W'(m_sum / 64'(m_cnt)));
            end
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic model_clear();
        m_sum = '0;
        m_cnt = 0;
        m_first = 1'b1;
    endtask

    task automatic pulse_clear(input int which, input string req);
        @(negedge clk);
        if (which == 0) sw_clear = 1'b1;
        else if (which == 1) hw_clear = 1'b1;
        else ref_switch = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0; hw_clear = 1'b0; ref_switch = 1'b0;
        model_clear();
        check(!hist_valid && hist_word == '0, req, {15'd0, hist_valid, hist_word}, 64'd0);
    endtask

    function automatic logic [WORD_W-1:0] rnd48();
        return {$urandom(), $urandom()} >> 16;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        logic [WORD_W-1:0] saved;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(hist_word == '0 && !hist_valid && !hist_strobe, "R1 reset",
              {14'd0, hist_strobe, hist_valid, hist_word}, 64'd0);
        rst_n = 1'b1;
        interval_len = 16'd16;
        early_cnt = 3'd0;
        repeat (2) @(negedge clk);

        // R2/R4: first full interval, K = 0
        for (int i = 0; i < 15; i++) send(rnd48(), GAP);
        check(!hist_valid && n_strobe == 0, "R4 nothing before full interval",
              64'(n_strobe), 64'd0);
        send(rnd48(), GAP);
        check(hist_valid && n_strobe == 1, "R9 valid after first result", 64'(n_strobe), 64'd1);

        // R2/R11: second interval, words near full scale
        for (int i = 0; i < 16; i++) send(48'hFFFF_FFFF_FFFF - 48'(i), GAP);
        check(n_strobe == 2, "R2 second interval result", 64'(n_strobe), 64'd2);

        // R6 + R5: software clear, K = 4, T = 16 -> n = 1,2,4,8 then 16
        early_cnt = 3'd4;
        pulse_clear(0, "R6 sw clear");
        s0 = n_strobe;
        for (int i = 0; i < 16; i++) send(48'(1000 + 37 * i), GAP);
        check(n_strobe - s0 == 5, "R5 early count K=4", 64'(n_strobe - s0), 64'd5);
        s0 = n_strobe;
        for (int i = 0; i < 16; i++) send(rnd48(), GAP);
        check(n_strobe - s0 == 1, "R5 no early after first", 64'(n_strobe - s0), 64'd1);

        // R6 + R5: hardware clear, K = 3, T = 20 -> n = 2,5,10 then 20
        interval_len = 16'd20;
        early_cnt = 3'd3;
        pulse_clear(1, "R6 hw clear");
        s0 = n_strobe;
        for (int i = 0; i < 20; i++) send(rnd48(), GAP);
        check(n_strobe - s0 == 4, "R5 early count K=3 T=20", 64'(n_strobe - s0), 64'd4);

        // R7: switch with keep set has no effect
        early_cnt = 3'd0;
        for (int i = 0; i < 7; i++) send(rnd48(), GAP);
        saved = hist_word;
        keep_hist = 1'b1;
        @(negedge clk); ref_switch = 1'b1;
        @(negedge clk); ref_switch = 1'b0;
        repeat (2) @(negedge clk);
        check(hist_valid && hist_word == saved, "R7 keep history", 64'(hist_word), 64'(saved));
        s0 = n_strobe;
        for (int i = 0; i < 13; i++) send(rnd48(), GAP);
        check(n_strobe - s0 == 1, "R7 sum kept across switch", 64'(n_strobe - s0), 64'd1);

        // R7: switch without keep clears
        keep_hist = 1'b0;
        pulse_clear(2, "R7 switch clears");

        // R8: zero interval ignores samples
        interval_len = 16'd0;
        s0 = n_strobe;
        for (int i = 0; i < 5; i++) send(48'hABCD_0000_0000, 10);
        repeat (GAP) @(negedge clk);
        check(n_strobe == s0 && !hist_valid, "R8 zero interval idle", 64'(n_strobe - s0), 64'd0);
        interval_len = 16'd4;
        for (int i = 0; i < 4; i++) send(48'(100 + i), GAP);
        check(n_strobe - s0 == 1, "R8 samples ignored", 64'(n_strobe - s0), 64'd1);

        // R10: clear together with a sample drops the sample
        @(negedge clk);
        ftw_in = 48'hFFFF_FFFF_FFFF; ftw_vld = 1'b1; sw_clear = 1'b1;
        @(negedge clk);
        ftw_vld = 1'b0; sw_clear = 1'b0;
        model_clear();
        s0 = n_strobe;
        for (int i = 0; i < 4; i++) send(48'(8 * i), GAP);
        check(n_strobe - s0 == 1 && hist_word == 48'd12, "R10 clear wins", 64'(hist_word), 64'd12);

        // R6: clear while a division is in flight drops it
        for (int i = 0; i < 3; i++) send(48'(50 + i), GAP);
        s0 = n_strobe;
        send(48'd53, 0);
        repeat (5) @(negedge clk);
        @(negedge clk); hw_clear = 1'b1;
        @(negedge clk); hw_clear = 1'b0;
        void'(exp_q.pop_back());
        model_clear();
        repeat (GAP + 10) @(negedge clk);
        check(n_strobe == s0 && !hist_valid, "R6 in-flight result dropped",
              64'(n_strobe - s0), 64'd0);
        for (int i = 0; i < 4; i++) send(48'(4 + 4 * i), GAP);
        check(hist_word == 48'd10, "R6 restart after abort", 64'(hist_word), 64'd10);

        repeat (GAP) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule